// File: doc/BRIEF.md
# SIMD Lane Arithmetic and Compare Unit

This unit applies one of sixteen integer operations to every lane of two 64-bit vectors at once. The `src` vector is always the left-hand operand and `dst` is the right-hand operand. The result is meant to be written back over the destination register. A single lane-size input splits the vector in one of two ways: four 16-bit lanes or eight 8-bit lanes. Lanes never carry into one another.

The sixteen codes fall into three groups:
- Wrapping arithmetic: add, subtract and reverse subtract.
- Signed saturating arithmetic: the same three forms, clamped to the lane's signed range.
- Predicates: each writes a whole lane of ones when its condition holds and a lane of zeros when it does not. The conditions are equality, inequality, carry out, the unsigned orderings taken from a borrow, and two's-complement overflow.

The datapath is combinational. A build parameter chooses whether the result passes through one output register; the default is registered.

Top module: `simd_alu`

## Requirements
- R1: Code 0 gives src+dst, code 1 gives src−dst and code 2 gives dst−src, each lane wrapping modulo 2^lane width.
- R2: Code 3 puts all-ones in a lane whose src and dst are equal and zero otherwise; code 7 gives the opposite mask.
- R3: Code 4 puts all-ones in a lane where unsigned src+dst carries out of the lane, zero otherwise.
- R4: Code 5 gives all-ones where src < dst (unsigned, from the borrow of src−dst); code 11 (0xB) gives all-ones where src ≥ dst.
- R5: Code 6 gives all-ones where src > dst (unsigned, from the borrow of dst−src); code 15 (0xF) gives all-ones where src ≤ dst.
- R6: Codes 8, 9 and 10 (0xA) compute src+dst, src−dst and dst−src as signed values and clamp the result to 0x7FFF/0x8000 for 16-bit lanes and to 0x7F/0x80 for 8-bit lanes.
- R7: Codes 12, 13 and 14 (0xC, 0xD, 0xE) give all-ones where src+dst, src−dst or dst−src, in that order, overflows the signed lane range, zero otherwise.
- R8: When lane_sz is 0 there are four 16-bit lanes, lane k at bits 16k+15:16k. When lane_sz is 1 there are eight 8-bit lanes, lane k at bits 8k+7:8k, so byte lane 0 is the low byte of word 0. No carry or borrow crosses a lane boundary.
- R9: With the default registered build, result shows the operation on the inputs present at the previous rising clock edge, and result is zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_sz | input | 1 | 0: four 16-bit lanes, 1: eight 8-bit lanes |
| op | input | 4 | Operation code |
| src | input | 64 | Left-hand operand vector |
| dst | input | 64 | Right-hand operand vector |
| result | output | 64 | Lane-wise result vector |

## Verification
The bench aims at the sign boundaries 0x7FFF/0x8000 and 0x7F/0x80. There, a saturation unit that clamps toward the wrong end, or that clamps on unsigned carry, returns a value of the wrong sign. It also feeds byte lanes full of 0xFF in 8-bit mode. A design that lets a carry or borrow leak into the next byte would corrupt the neighbouring lane. Compares on equal operands separate src<dst from src≤dst, which catches a ≥/> predicate that uses the wrong operand order or misses its inversion. The reverse-subtract codes are driven with asymmetric operands, so swapped operands show up as negated results.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'h0,
        OP_SUB    = 4'h1,
        OP_RSUB   = 4'h2,
        OP_EQ     = 4'h3,
        OP_CARRY  = 4'h4,
        OP_LTU    = 4'h5,
        OP_GTU    = 4'h6,
        OP_NE     = 4'h7,
        OP_ADDS   = 4'h8,
        OP_SUBS   = 4'h9,
        OP_RSUBS  = 4'hA,
        OP_GEU    = 4'hB,
        OP_OVADD  = 4'hC,
        OP_OVSUB  = 4'hD,
        OP_OVRSUB = 4'hE,
        OP_LEU    = 4'hF
    } simd_op_e;

    typedef enum logic {
        LANES_WIDE   = 1'b0,
        LANES_NARROW = 1'b1
    } lane_sz_e;

    function automatic logic op_is_mask(input simd_op_e o);
        return !(o inside {OP_ADD, OP_SUB, OP_RSUB, OP_ADDS, OP_SUBS, OP_RSUBS});
    endfunction

endpackage

// File: rtl/simd_lane_op.sv
module simd_lane_op
    import simd_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  simd_op_e     op,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] ALL1 = {W{1'b1}};

    logic [W:0] sum_x, dif_ab, dif_ba;
    logic       ov_add, ov_ab, ov_ba;
    logic       hit;

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b};
        dif_ab = {1'b0, a} - {1'b0, b};
        dif_ba = {1'b0, b} - {1'b0, a};
        ov_add = (a[W-1] == b[W-1]) && (sum_x[W-1]  != a[W-1]);
        ov_ab  = (a[W-1] != b[W-1]) && (dif_ab[W-1] != a[W-1]);
        ov_ba  = (a[W-1] != b[W-1]) && (dif_ba[W-1] != b[W-1]);
    end

    always_comb begin
        hit = 1'b0;
        y   = '0;
        unique case (op)
            OP_ADD:    y = sum_x[W-1:0];
            OP_SUB:    y = dif_ab[W-1:0];
            OP_RSUB:   y = dif_ba[W-1:0];
            OP_ADDS:   y = ov_add ? (a[W-1] ? SMIN : SMAX) : sum_x[W-1:0];
            OP_SUBS:   y = ov_ab  ? (a[W-1] ? SMIN : SMAX) : dif_ab[W-1:0];
            OP_RSUBS:  y = ov_ba  ? (b[W-1] ? SMIN : SMAX) : dif_ba[W-1:0];
            OP_EQ:     hit = (a == b);
            OP_NE:     hit = (a != b);
            OP_CARRY:  hit = sum_x[W];
            OP_LTU:    hit = dif_ab[W];
            OP_GEU:    hit = !dif_ab[W];
            OP_GTU:    hit = dif_ba[W];
            OP_LEU:    hit = !dif_ba[W];
            OP_OVADD:  hit = ov_add;
            OP_OVSUB:  hit = ov_ab;
            OP_OVRSUB: hit = ov_ba;
            default:   hit = 1'b0;
        endcase
        if (op_is_mask(op)) y = hit ? ALL1 : '0;
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_alu_pkg::*;
#(
    parameter int VEC_W  = 64,
    parameter int LANE_W = 16
) (
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    input  simd_op_e         op,
    output logic [VEC_W-1:0] y
);
    localparam int NLANES = VEC_W / LANE_W;

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        simd_lane_op #(.W(LANE_W)) u_lane (
            .a  (src[k*LANE_W +: LANE_W]),
            .b  (dst[k*LANE_W +: LANE_W]),
            .op (op),
            .y  (y[k*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_alu_pkg::*;
#(
    parameter int VEC_W      = 64,
    parameter int WIDE_W     = 16,
    parameter int NARROW_W   = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane_sz,
    input  logic [3:0]       op,
    input  logic [VEC_W-1:0] src,
    input  logic [VEC_W-1:0] dst,
    output logic [VEC_W-1:0] result
);
    simd_op_e         op_e;
    lane_sz_e         sz_e;
    logic [VEC_W-1:0] wide_y, narrow_y, sel_y;

    assign op_e = simd_op_e'(op);
    assign sz_e = lane_sz_e'(lane_sz);

    simd_lane_bank #(.VEC_W(VEC_W), .LANE_W(WIDE_W)) u_wide (
        .src (src), .dst (dst), .op (op_e), .y (wide_y)
    );

    simd_lane_bank #(.VEC_W(VEC_W), .LANE_W(NARROW_W)) u_narrow (
        .src (src), .dst (dst), .op (op_e), .y (narrow_y)
    );

    always_comb begin
        unique case (sz_e)
            LANES_WIDE:   sel_y = wide_y;
            LANES_NARROW: sel_y = narrow_y;
            default:      sel_y = wide_y;
        endcase
    end

    if (REGISTERED) begin : g_reg
        logic [VEC_W-1:0] res_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= sel_y;
        end
        assign result = res_q;
    end else begin : g_comb
        assign result = sel_y;
    end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
    import simd_alu_pkg::*;
#(
    parameter int VEC_W      = 64,
    parameter int WIDE_W     = 16,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lane_sz,
    input logic [3:0]       op,
    input logic [VEC_W-1:0] src,
    input logic [VEC_W-1:0] dst,
    input logic [VEC_W-1:0] result
);
    localparam int NW = VEC_W / WIDE_W;
    localparam logic [WIDE_W-1:0] W1 = {WIDE_W{1'b1}};

    logic             v_s;
    logic             sz_s;
    simd_op_e         op_s;
    logic [VEC_W-1:0] src_s, dst_s;

    if (REGISTERED) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_s <= 1'b0; sz_s <= 1'b0; op_s <= OP_ADD;
                src_s <= '0; dst_s <= '0;
            end else begin
                v_s <= 1'b1; sz_s <= lane_sz; op_s <= simd_op_e'(op);
                src_s <= src; dst_s <= dst;
            end
        end
    end else begin : g_now
        assign v_s = 1'b1;
        assign sz_s = lane_sz;
        assign op_s = simd_op_e'(op);
        assign src_s = src;
        assign dst_s = dst;
    end

    // R2
    eq_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && op_s == OP_EQ && src_s == dst_s) |-> (result == '1));

    // R2
    ne_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && op_s == OP_NE && src_s == dst_s) |-> (result == '0));

    // R1
    sub_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && op_s == OP_SUB && src_s == dst_s) |-> (result == '0));

    // R4
    geu_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && op_s == OP_GEU && src_s == dst_s) |-> (result == '1));

    // R7
    ovadd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (v_s && op_s == OP_OVADD && dst_s == '0) |-> (result == '0));

    for (genvar k = 0; k < NW; k++) begin : g_mask
        // R8
        lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (v_s && !sz_s && op_is_mask(op_s)) |->
            (result[k*WIDE_W +: WIDE_W] == '0 || result[k*WIDE_W +: WIDE_W] == W1));
    end
endmodule

bind simd_alu simd_alu_chk #(
    .VEC_W(VEC_W), .WIDE_W(WIDE_W), .REGISTERED(REGISTERED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lane_sz(lane_sz), .op(op),
    .src(src), .dst(dst), .result(result)
);

// File: tb/sim_simd_alu.sv
module sim_simd_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lane_sz = 1'b0;
    logic [3:0]  op = 4'h0;
    logic [63:0] src = '0, dst = '0;
    logic [63:0] result;
    int          n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    simd_alu u0 (.clk(clk), .rst_n(rst_n), .lane_sz(lane_sz), .op(op),
                 .src(src), .dst(dst), .result(result));

    function automatic longint clampv(longint v, longint half);
        if (v > half - 1) return half - 1;
        if (v < -half) return -half;
        return v;
    endfunction

    function automatic longint flag(bit c);
        return c ? -64'sd1 : 64'sd0;
    endfunction

    function automatic logic [63:0] model(logic [63:0] s, logic [63:0] d,
                                          logic [3:0] o, logic sz);
        int w = sz ? 8 : 16;
        longint full = longint'(1) << w;
        longint half = full >> 1;
        logic [63:0] acc = '0;
        for (int k = 0; k < 64 / w; k++) begin
            longint a = longint'((s >> (k * w)) & 64'(full - 1));
            longint b = longint'((d >> (k * w)) & 64'(full - 1));
            longint sa = (a >= half) ? a - full : a;
            longint sb = (b >= half) ? b - full : b;
            longint r;
            case (o)
                4'h0: r = a + b;
                4'h1: r = a - b;
                4'h2: r = b - a;
                4'h3: r = flag(a == b);
                4'h4: r = flag(a + b >= full);
                4'h5: r = flag(a < b);
                4'h6: r = flag(a > b);
                4'h7: r = flag(a != b);
                4'h8: r = clampv(sa + sb, half);
                4'h9: r = clampv(sa - sb, half);
                4'hA: r = clampv(sb - sa, half);
                4'hB: r = flag(a >= b);
                4'hC: r = flag(clampv(sa + sb, half) != sa + sb);
                4'hD: r = flag(clampv(sa - sb, half) != sa - sb);
                4'hE: r = flag(clampv(sb - sa, half) != sb - sa);
                default: r = flag(a <= b);
            endcase
            acc = acc | (64'(r & (full - 1)) << (k * w));
        end
        return acc;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'h0, 4'h1, 4'h2:        return "R1";
            4'h3, 4'h7:              return "R2";
            4'h4:                    return "R3";
            4'h5, 4'hB:              return "R4";
            4'h6, 4'hF:              return "R5";
            4'h8, 4'h9, 4'hA:        return "R6";
            4'hC, 4'hD, 4'hE:        return "R7";
            default:                 return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(logic sz, logic [3:0] o, logic [63:0] s, logic [63:0] d, string req);
        @(negedge clk);
        lane_sz = sz; op = o; src = s; dst = d;
        @(negedge clk);
        check(req, result, model(s, d, o, sz));
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_up();
    end

    initial begin
        void'($urandom(32'd2024));
        op = 4'h0; src = 64'h1111_2222_3333_4444; dst = 64'h0101_0101_0101_0101;
        repeat (3) @(negedge clk);
        check("R9", result, 64'h0);
        rst_n = 1'b1;

        // R9: before the next edge the output still holds the previous value
        run(1'b0, 4'h0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040, "R9");
        @(negedge clk);
        op = 4'h1; src = 64'hFFFF_FFFF_FFFF_FFFF; dst = 64'h1;
        #1 check("R9", result, 64'h0011_0022_0033_0044);
        @(negedge clk);
        check("R9", result, model(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'h1, 1'b0));

        // R6 sign boundaries
        run(1'b0, 4'h8, 64'h7FFF_8000_7FFF_0001, 64'h0001_FFFF_7FFF_0001, "R6");
        run(1'b0, 4'h9, 64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_0000, "R6");
        run(1'b0, 4'hA, 64'h0001_FFFF_8000_0000, 64'h8000_7FFF_0000_8000, "R6");
        run(1'b1, 4'h8, 64'h7F80_7F80_0102_7F7F, 64'h01FF_0101_7F80_7F7F, "R6");
        run(1'b1, 4'h9, 64'h807F_8000_7F80_0101, 64'h01FF_7F80_807F_0101, "R6");
        // R7 overflow edges
        run(1'b0, 4'hC, 64'h7FFF_8000_7FFF_1234, 64'h0001_8000_8000_0001, "R7");
        run(1'b0, 4'hD, 64'h8000_7FFF_0000_8000, 64'h0001_FFFF_8000_0000, "R7");
        run(1'b0, 4'hE, 64'h0001_FFFF_8000_0000, 64'h8000_7FFF_0000_8000, "R7");
        // R8 lane isolation: all-ones bytes plus one must not carry into neighbours
        run(1'b1, 4'h0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, "R8");
        run(1'b1, 4'h1, 64'h0100_0100_0100_0100, 64'h0001_0001_0001_0001, "R8");
        run(1'b0, 4'h0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, "R8");
        run(1'b1, 4'h4, 64'hFF01_FF01_FF01_FF01, 64'h0101_0101_0101_0101, "R3");
        // R4 / R5 on equal operands
        run(1'b0, 4'h5, 64'h1234_1234_0000_FFFF, 64'h1234_1235_0001_FFFF, "R4");
        run(1'b0, 4'hB, 64'h1234_1234_0000_FFFF, 64'h1234_1235_0001_FFFF, "R4");
        run(1'b1, 4'h6, 64'h1234_1234_0000_FFFF, 64'h1234_1235_0001_FFFE, "R5");
        run(1'b1, 4'hF, 64'h1234_1234_0000_FFFF, 64'h1234_1235_0001_FFFE, "R5");
        run(1'b0, 4'h3, 64'hAAAA_5555_0000_FFFF, 64'hAAAA_5554_0000_FFFE, "R2");
        run(1'b1, 4'h7, 64'hAAAA_5555_0000_FFFF, 64'hAAAA_5554_0000_FFFE, "R2");
        run(1'b0, 4'h2, 64'h0003_0000_0010_8000, 64'h0001_0001_0020_0001, "R1");

        // constrained random: operands biased toward lane boundaries
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 16; o++) begin
                for (int n = 0; n < 40; n++) begin
                    logic [63:0] s, d;
                    s = {$urandom, $urandom};
                    d = {$urandom, $urandom};
                    if (n % 4 == 0) d = s;
                    if (n % 4 == 1) s = s | 64'h8080_8080_8080_8080;
                    if (n % 4 == 2) d = d & 64'h7F7F_7F7F_7F7F_7F7F;
                    run(m[0], o[3:0], s, d, (n % 8 == 7) ? "R8" : tag_of(o[3:0]));
                end
            end
        end
        finish_up();
    end
endmodule